// File: doc/BRIEF.md
# Segmented TDMA Bus Arbiter

This block decides which of several cores may drive a shared bus in each clock cycle, using a fixed time-division plan. The plan is a set of segments. Each segment lists every core exactly once as a sequence of slots, and each slot has a length in cycles. The active segment plays its slots in order and then starts again from its first slot. It keeps repeating until a different segment is made active.

A task-activation event names the segment that should run next. The arbiter records the request and changes segment only when the running segment reaches the end of its period, so a slot is never cut short. The grant follows the owner of the current slot. It is raised only if that owner is requesting. An unused slot stays empty and is not handed to another core, which keeps worst-case latency the same as plain round-robin.

Two mode bits narrow the plan. One makes every slot last the same number of cycles, taken from a single shared length register. The other pins the schedule to segment 0, so activation events have no effect.

Top module: `tdma_seg_arbiter`

## Requirements
- R1: After reset the arbiter is in segment 0, slot 0, at the first cycle of that slot. Every table entry resets to owner = slot index and length = 1, and the shared equal length resets to 1. With all requests high, the grant right after reset is 4'b0001 and `seg_now` is 0.
- R2: `gnt` has at most one bit set in every cycle.
- R3: `gnt[i]` is high only when core i owns the current slot and `req[i]` is high. A slot whose owner is idle grants nobody, whatever the other cores request.
- R4: With `mode[0]` = 0, slot k of the active segment lasts the length stored for that slot, in cycles. Slots run in order 0 to NUM_CORES-1 and then wrap to slot 0. The owner of a slot is the core index stored in its table entry.
- R5: With `mode[0]` = 1, every slot lasts the shared equal length and the per-slot lengths are ignored.
- R6: An activation (`act_valid` high with `act_seg`) takes effect only when the last slot of the running segment ends. `seg_now` shows the new segment from the following cycle, which is the first cycle of slot 0.
- R7: If more than one activation arrives before a period ends, the most recent one wins. An activation that arrives in the same cycle as a period end is applied at the next period end.
- R8: With `mode[1]` = 1, activations are discarded and any pending one is dropped. At the next period end the segment becomes 0, and it then stays 0.
- R9: A stored length of 0, whether per-slot or shared, counts as a length of 1 cycle.
- R10: A table write (`tbl_we` high) stores `tbl_owner` and `tbl_len` into entry (`tbl_seg`, `tbl_slot`). `eq_we` stores `eq_len_wr` as the shared length. Both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CORES | Per-core bus request |
| gnt | output | NUM_CORES | One-hot (or zero) bus grant |
| seg_now | output | $clog2(NUM_SEGS) | Segment currently being played |
| mode | input | 2 | Bit 0: equal slot lengths; bit 1: fixed segment 0 |
| act_valid | input | 1 | Task-activation event |
| act_seg | input | $clog2(NUM_SEGS) | Segment requested by the activation |
| tbl_we | input | 1 | Segment-table write enable |
| tbl_seg | input | $clog2(NUM_SEGS) | Segment of the entry written |
| tbl_slot | input | $clog2(NUM_CORES) | Slot of the entry written |
| tbl_owner | input | $clog2(NUM_CORES) | Core index stored as the slot owner |
| tbl_len | input | LEN_W | Slot length in cycles |
| eq_we | input | 1 | Write enable for the shared equal length |
| eq_len_wr | input | LEN_W | Shared equal slot length |

## Verification
The bench builds the arbiter with NUM_CORES = 4, NUM_SEGS = 4 and LEN_W = 8. At these sizes every segment, every slot position and every owner can be programmed, and each one is visited within a few hundred cycles. A reference model kept in the bench predicts `gnt` and `seg_now` cycle by cycle. The runs cover several permuted owner orders and unequal lengths, including zero-length entries, as well as pseudo-random request patterns with idle owners. They also cover activations placed mid-period, back-to-back and on the period-end cycle, plus both mode bits. As a result the timing of each segment switch and the handling of each slot boundary are compared exactly, not just sampled.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    // Mode input decoded as a packed struct: bit 1 pins segment 0, bit 0 equalises slots.
    typedef struct packed {
        logic one_seg;
        logic eq_slots;
    } mode_t;

    // Effective slot length: a zero entry is treated as one cycle.
    function automatic logic [15:0] eff_len(input logic [15:0] raw);
        return (raw == 16'd0) ? 16'd1 : raw;
    endfunction

endpackage

// File: rtl/tdma_seg_table.sv
module tdma_seg_table #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEGS  = 4,
    parameter int LEN_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_CORES),
    localparam int SEG_W    = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [SLOT_W-1:0] wr_owner,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              eq_wr_en,
    input  logic [LEN_W-1:0]  eq_wr_len,
    input  logic [SEG_W-1:0]  rd_seg,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [SLOT_W-1:0] rd_owner,
    output logic [LEN_W-1:0]  rd_len,
    output logic [LEN_W-1:0]  eq_len
);

    logic [SLOT_W-1:0] own_q [NUM_SEGS][NUM_CORES];
    logic [SLOT_W-1:0] own_d [NUM_SEGS][NUM_CORES];
    logic [LEN_W-1:0]  len_q [NUM_SEGS][NUM_CORES];
    logic [LEN_W-1:0]  len_d [NUM_SEGS][NUM_CORES];
    logic [LEN_W-1:0]  eq_q, eq_d;

    always_comb begin
        own_d = own_q;
        len_d = len_q;
        eq_d  = eq_q;
        for (int s = 0; s < NUM_SEGS; s++) begin
            for (int k = 0; k < NUM_CORES; k++) begin
                if (wr_en && wr_seg == SEG_W'(s) && wr_slot == SLOT_W'(k)) begin
                    own_d[s][k] = wr_owner;
                    len_d[s][k] = wr_len;
                end
            end
        end
        if (eq_wr_en) eq_d = eq_wr_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SEGS; s++) begin
                for (int k = 0; k < NUM_CORES; k++) begin
                    own_q[s][k] <= SLOT_W'(k);
                    len_q[s][k] <= LEN_W'(1);
                end
            end
            eq_q <= LEN_W'(1);
        end else begin
            own_q <= own_d;
            len_q <= len_d;
            eq_q  <= eq_d;
        end
    end

    assign rd_owner = own_q[rd_seg][rd_slot];
    assign rd_len   = len_q[rd_seg][rd_slot];
    assign eq_len   = eq_q;

endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer
    import tdma_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEGS  = 4,
    parameter int LEN_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_CORES),
    localparam int SEG_W    = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic [LEN_W-1:0]  eq_len,
    input  logic              act_valid,
    input  logic [SEG_W-1:0]  act_seg,
    output logic [SEG_W-1:0]  seg,
    output logic [SLOT_W-1:0] slot,
    output logic [LEN_W-1:0]  cyc
);

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [SLOT_W-1:0] slot;
        logic [LEN_W-1:0]  cyc;
        logic              pend_v;
        logic [SEG_W-1:0]  pend_seg;
    } tstate_t;

    tstate_t st_q, st_d;

    logic [LEN_W-1:0] raw_len;
    logic [LEN_W:0]   len_ext;
    logic [LEN_W:0]   cyc_nxt;
    logic             slot_end;
    logic             last_slot;
    logic             period_end;

    always_comb begin
        raw_len    = mode.eq_slots ? eq_len : slot_len;
        len_ext    = (LEN_W+1)'(eff_len(16'(raw_len)));
        cyc_nxt    = {1'b0, st_q.cyc} + 1'b1;
        slot_end   = (cyc_nxt >= len_ext);
        last_slot  = (st_q.slot == SLOT_W'(NUM_CORES - 1));
        period_end = slot_end && last_slot;

        st_d = st_q;
        if (slot_end) begin
            st_d.cyc  = '0;
            st_d.slot = last_slot ? '0 : st_q.slot + 1'b1;
        end else begin
            st_d.cyc = cyc_nxt[LEN_W-1:0];
        end

        if (period_end) begin
            if (mode.one_seg) begin
                st_d.seg = '0;
            end else if (st_q.pend_v) begin
                st_d.seg = st_q.pend_seg;
            end
            st_d.pend_v = 1'b0;
        end

        if (mode.one_seg) begin
            st_d.pend_v = 1'b0;
        end else if (act_valid) begin
            st_d.pend_v   = 1'b1;
            st_d.pend_seg = act_seg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg  = st_q.seg;
    assign slot = st_q.slot;
    assign cyc  = st_q.cyc;

endmodule

// File: rtl/tdma_grant_gen.sv
module tdma_grant_gen #(
    parameter int NUM_CORES = 4,
    localparam int SLOT_W   = $clog2(NUM_CORES)
) (
    input  logic [NUM_CORES-1:0] req,
    input  logic [SLOT_W-1:0]    owner,
    output logic [NUM_CORES-1:0] gnt
);

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        assign gnt[i] = req[i] && (owner == SLOT_W'(i));
    end

endmodule

// File: rtl/tdma_seg_arbiter.sv
module tdma_seg_arbiter
    import tdma_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEGS  = 4,
    parameter int LEN_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_CORES),
    localparam int SEG_W    = $clog2(NUM_SEGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] gnt,
    output logic [SEG_W-1:0]     seg_now,
    input  logic [1:0]           mode,
    input  logic                 act_valid,
    input  logic [SEG_W-1:0]     act_seg,
    input  logic                 tbl_we,
    input  logic [SEG_W-1:0]     tbl_seg,
    input  logic [SLOT_W-1:0]    tbl_slot,
    input  logic [SLOT_W-1:0]    tbl_owner,
    input  logic [LEN_W-1:0]     tbl_len,
    input  logic                 eq_we,
    input  logic [LEN_W-1:0]     eq_len_wr
);

    mode_t             mode_s;
    logic [SLOT_W-1:0] slot_idx;
    logic [LEN_W-1:0]  cyc_idx;
    logic [SLOT_W-1:0] cur_owner;
    logic [LEN_W-1:0]  cur_len;
    logic [LEN_W-1:0]  eq_len;

    assign mode_s = mode_t'(mode);

    tdma_seg_table #(
        .NUM_CORES(NUM_CORES), .NUM_SEGS(NUM_SEGS), .LEN_W(LEN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_seg   (tbl_seg),
        .wr_slot  (tbl_slot),
        .wr_owner (tbl_owner),
        .wr_len   (tbl_len),
        .eq_wr_en (eq_we),
        .eq_wr_len(eq_len_wr),
        .rd_seg   (seg_now),
        .rd_slot  (slot_idx),
        .rd_owner (cur_owner),
        .rd_len   (cur_len),
        .eq_len   (eq_len)
    );

    tdma_slot_timer #(
        .NUM_CORES(NUM_CORES), .NUM_SEGS(NUM_SEGS), .LEN_W(LEN_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_s),
        .slot_len (cur_len),
        .eq_len   (eq_len),
        .act_valid(act_valid),
        .act_seg  (act_seg),
        .seg      (seg_now),
        .slot     (slot_idx),
        .cyc      (cyc_idx)
    );

    tdma_grant_gen #(
        .NUM_CORES(NUM_CORES)
    ) u_grant (
        .req  (req),
        .owner(cur_owner),
        .gnt  (gnt)
    );

endmodule

// File: rtl/tdma_seg_arbiter_chk.sv
module tdma_seg_arbiter_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEGS  = 4,
    parameter int LEN_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_CORES),
    localparam int SEG_W    = $clog2(NUM_SEGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] req,
    input logic [NUM_CORES-1:0] gnt,
    input logic [1:0]           mode,
    input logic [SEG_W-1:0]     seg_now,
    input logic [SLOT_W-1:0]    slot_idx,
    input logic [LEN_W-1:0]     cyc_idx
);

    // R2: never more than one grant
    a_r2_onehot_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3: a grant only ever goes to a requesting core
    a_r3_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0));

    // R4: slot index moves only at a slot start, by one or back to zero
    a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_idx) |-> (cyc_idx == '0) &&
            ((slot_idx == SLOT_W'($past(slot_idx) + 1'b1)) || (slot_idx == '0)));

    // R6: the segment changes only on the first cycle of slot 0
    a_r6_switch_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seg_now) |-> (slot_idx == '0) && (cyc_idx == '0));

    // R8: with segment pinning on, segment 0 is never left
    a_r8_pinned_seg: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && seg_now == '0) |=> (seg_now == '0));

endmodule

bind tdma_seg_arbiter tdma_seg_arbiter_chk #(
    .NUM_CORES(NUM_CORES), .NUM_SEGS(NUM_SEGS), .LEN_W(LEN_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .gnt     (gnt),
    .mode    (mode),
    .seg_now (seg_now),
    .slot_idx(slot_idx),
    .cyc_idx (cyc_idx)
);

// File: tb/test_tdma_seg_arbiter.sv
`timescale 1ns/1ps
module test_tdma_seg_arbiter;

    localparam int NC = 4;
    localparam int NS = 4;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req = '0;
    logic [NC-1:0] gnt;
    logic [1:0]    seg_now;
    logic [1:0]    mode = 2'b00;
    logic          act_valid = 1'b0;
    logic [1:0]    act_seg = '0;
    logic          tbl_we = 1'b0;
    logic [1:0]    tbl_seg = '0;
    logic [1:0]    tbl_slot = '0;
    logic [1:0]    tbl_owner = '0;
    logic [LW-1:0] tbl_len = '0;
    logic          eq_we = 1'b0;
    logic [LW-1:0] eq_len_wr = '0;

    always #2 clk = ~clk;

    tdma_seg_arbiter #(.NUM_CORES(NC), .NUM_SEGS(NS), .LEN_W(LW)) i_tdma_seg_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .seg_now(seg_now),
        .mode(mode), .act_valid(act_valid), .act_seg(act_seg),
        .tbl_we(tbl_we), .tbl_seg(tbl_seg), .tbl_slot(tbl_slot),
        .tbl_owner(tbl_owner), .tbl_len(tbl_len),
        .eq_we(eq_we), .eq_len_wr(eq_len_wr)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int mown [NS][NC];
    int mlen [NS][NC];
    int meq;
    int ms, mk, mc, mpv, mps;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (seg=%0d slot=%0d cyc=%0d)", t, act, exp, ms, mk, mc);
        end
    endtask

    task automatic check_outputs();
        int o;
        logic [NC-1:0] eg;
        o  = mown[ms][mk];
        eg = req[o] ? NC'(1 << o) : '0;
        check({tag, " gnt"}, 32'(gnt), 32'(eg));
        check({tag, " seg_now"}, 32'(seg_now), 32'(ms));
    endtask

    // one clock: model next state from current inputs, then compare after the edge
    task automatic step();
        int L, nk, nc, ns, npv, nps;
        bit send, pend;
        L = mode[0] ? meq : mlen[ms][mk];
        if (L == 0) L = 1;              // R9
        send = (mc + 1 >= L);
        pend = send && (mk == NC - 1);
        nk = send ? ((mk == NC - 1) ? 0 : mk + 1) : mk;
        nc = send ? 0 : mc + 1;
        ns = ms; npv = mpv; nps = mps;
        if (pend) begin
            if (mode[1]) ns = 0;
            else if (mpv != 0) ns = mps;
            npv = 0;
        end
        if (mode[1]) npv = 0;
        else if (act_valid) begin npv = 1; nps = int'(act_seg); end
        if (tbl_we) begin
            mown[tbl_seg][tbl_slot] = int'(tbl_owner);
            mlen[tbl_seg][tbl_slot] = int'(tbl_len);
        end
        if (eq_we) meq = int'(eq_len_wr);
        @(posedge clk);
        #1;
        ms = ns; mk = nk; mc = nc; mpv = npv; mps = nps;
        check_outputs();
    endtask

    task automatic run(input int n, input bit rnd);
        for (int i = 0; i < n; i++) begin
            if (rnd) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                req  = lfsr[3:0];
            end
            step();
        end
    endtask

    // R10: table write through the port
    task automatic wr(input int s, input int k, input int o, input int l);
        tbl_we = 1'b1; tbl_seg = 2'(s); tbl_slot = 2'(k); tbl_owner = 2'(o); tbl_len = LW'(l);
        step();
        tbl_we = 1'b0;
    endtask

    task automatic activate(input int s);
        act_valid = 1'b1; act_seg = 2'(s);
        step();
        act_valid = 1'b0;
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NC; k++) begin mown[s][k] = k; mlen[s][k] = 1; end
        meq = 1; ms = 0; mk = 0; mc = 0; mpv = 0; mps = 0;

        req = 4'hF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 gnt after reset", 32'(gnt), 32'h1);
        check("R1 seg after reset", 32'(seg_now), 32'h0);

        tag = "R4 default order"; run(12, 0);

        tag = "R10 R4 programming";
        wr(1, 0, 2, 1); wr(1, 1, 0, 2); wr(1, 2, 3, 3); wr(1, 3, 1, 4);
        wr(2, 0, 3, 2); wr(2, 1, 2, 1); wr(2, 2, 1, 1); wr(2, 3, 0, 2);
        wr(3, 0, 1, 0); wr(3, 1, 3, 2); wr(3, 2, 0, 0); wr(3, 3, 2, 1);
        run(3, 0);

        tag = "R6 switch at period end"; activate(1); run(40, 0);

        tag = "R2 R3 random requests"; run(20, 1); activate(2); run(40, 1);

        tag = "R7 latest activation wins";
        req = 4'hF;
        activate(3); run(1, 0); activate(0); run(30, 0);
        // activation on every cycle across a boundary
        for (int i = 0; i < 8; i++) activate(i % 2 == 0 ? 1 : 2);
        run(40, 0);

        tag = "R9 zero length"; activate(3); run(40, 1);

        tag = "R5 equal slots";
        eq_we = 1'b1; eq_len_wr = 8'd3; mode = 2'b01;
        step(); eq_we = 1'b0;
        req = 4'hF; run(20, 0);
        wr(3, 1, 3, 7); run(20, 1);
        eq_we = 1'b1; eq_len_wr = 8'd0; step(); eq_we = 1'b0;   // R9 on shared length
        run(12, 0);

        tag = "R8 pinned segment";
        mode = 2'b10; activate(2); run(10, 0); activate(1); run(30, 1);
        check("R8 seg pinned to 0", 32'(seg_now), 32'h0);
        mode = 2'b11; activate(3); run(20, 0);

        tag = "R6 after unpinning"; mode = 2'b00; activate(2); run(30, 0);

        done = 1;
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1..all: actual=timeout expected=completion");
            finish_up();
        end
    end

endmodule